// File: doc/BRIEF.md
# Memory Power and Sleep Access Gate

This clocked block sits between a host and a memory controller. It decides when the controller may start memory accesses. It also drives the memory's active-low sleep pin, and it forces the memory's write enable inactive whenever the supply is not trusted. It has three inputs: a digital supply-good flag from an external voltage monitor, a sleep request from the host, and a busy flag from the controller that marks an access in flight.

After the supply becomes good, the gate holds off all accesses for a parameterised number of cycles before it grants the permit. A sleep request is only acted on once the controller is idle. While a request waits for the controller, the permit is withdrawn so that no new access can start. Once the sleep pin is low it stays low for a minimum number of cycles. When the request is released, the pin returns high and a second, separate holdoff runs before accesses resume. A supply loss overrides everything: the permit drops and the write hold rises in the same cycle.

Top module: `mem_pwr_gate`

## Requirements
- R1: When `supply_ok` is low, `access_ok` is low and `we_hold` is high in that same cycle, from any state. At the next clock edge the gate returns to its powered-off state, with `sleep_n` high.
- R2: After `supply_ok` is first sampled high in the powered-off state, `access_ok` stays low and `we_hold` stays high for PWRUP_CYC more edges. On edge PWRUP_CYC+1, counted from that first sample, `access_ok` rises and `we_hold` falls.
- R3: In the ready state, `sleep_req` high with `ctrl_busy` low drives `sleep_n` low and `access_ok` low on the next edge. Whenever `sleep_n` is low, `access_ok` is low.
- R4: In the ready state, `sleep_req` high with `ctrl_busy` high withdraws `access_ok` on the next edge and keeps `sleep_n` high. `sleep_n` falls on the edge after `ctrl_busy` is first sampled low, and never falls on an edge where `ctrl_busy` is sampled high.
- R5: If `sleep_req` is sampled low while the gate is waiting for the controller, it returns to ready on that edge: `access_ok` rises again, and `sleep_n` never falls.
- R6: Once `sleep_n` falls, it stays low for at least SLEEP_MIN_CYC+1 cycles, however short the request is.
- R7: After the minimum low time, `sleep_n` rises on the first edge that samples `sleep_req` low. `access_ok` rises WAKE_CYC edges later.
- R8: While `sleep_n` is low, `ctrl_busy` has no effect on any output.
- R9: A `sleep_req` that is held high during the power-up holdoff is not acted on until the holdoff ends. The gate grants `access_ok` for one cycle and then enters sleep on the following edge.
- R10: While `rst` is high, and on the first edge after it, `access_ok` is low, `sleep_n` is high and `we_hold` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | High when the supply is above the trip point |
| sleep_req | input | 1 | High to request the memory's low-power state |
| ctrl_busy | input | 1 | High while the controller has an access in flight |
| sleep_n | output | 1 | Memory sleep pin, low = sleep |
| we_hold | output | 1 | High forces the memory write enable inactive |
| access_ok | output | 1 | High when the controller may start an access |

## Verification
The bench drives inputs on the falling clock edge and samples one full cycle later, after each rising edge has updated the registers. Results that are combinational on `supply_ok` are the exception: the withdrawal of `access_ok` and the rise of `we_hold` are checked a delta after the input changes, before any edge. For every registered result, the bench computes the edge on which it is due from the holdoff, minimum-low and drain lengths, and then checks the output on every cycle of the window, not only at the end.

The bench sweeps the sleep request length from 1 to 6 cycles and the drain length from 1 to 3 cycles. For each case, the cycle in which `sleep_n` rises is computed as the later of SLEEP_MIN_CYC+2 and the release edge, and `access_ok` is then expected WAKE_CYC edges after that.

// File: rtl/mem_pwr_pkg.sv
package mem_pwr_pkg;

  // Gate states; order carries no meaning.
  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,  // supply below trip point
    ST_PWAIT     = 3'd1,  // power-up holdoff
    ST_READY     = 3'd2,  // accesses permitted
    ST_DRAIN     = 3'd3,  // sleep requested, waiting for controller idle
    ST_SLEEP_MIN = 3'd4,  // sleep pin low, minimum time running
    ST_SLEEP     = 3'd5,  // sleep pin low, waiting for request release
    ST_WAKE      = 3'd6   // sleep-exit holdoff
  } gate_st_e;

  function automatic logic st_asleep(gate_st_e s);
    return (s == ST_SLEEP_MIN) || (s == ST_SLEEP);
  endfunction

  function automatic logic st_timed(gate_st_e s);
    return (s == ST_PWAIT) || (s == ST_WAKE) || (s == ST_SLEEP_MIN);
  endfunction

endpackage

// File: rtl/mpg_timer.sv
module mpg_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  // Single down counter shared by every timed state.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

  // The count must never pass from zero to a nonzero value without a load (R6).
  assert_tmr_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);

endmodule

// File: rtl/mpg_fsm.sv
module mpg_fsm
  import mem_pwr_pkg::*;
#(
  parameter int unsigned PWRUP_CYC     = 45000,
  parameter int unsigned WAKE_CYC      = 45000,
  parameter int unsigned SLEEP_MIN_CYC = 100,
  parameter int          CNT_W         = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             supply_ok,
  input  logic             sleep_req,
  input  logic             ctrl_busy,
  input  logic             tmr_zero,
  output gate_st_e         state,
  output gate_st_e         nxt,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] PWRUP_LD = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LD  = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] MIN_LD   = CNT_W'(SLEEP_MIN_CYC - 1);

  always_comb begin
    nxt = state;
    if (!supply_ok) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:       nxt = ST_PWAIT;
        ST_PWAIT:     if (tmr_zero) nxt = ST_READY;
        ST_READY:     if (sleep_req) nxt = ctrl_busy ? ST_DRAIN : ST_SLEEP_MIN;
        ST_DRAIN: begin
          if (!sleep_req)      nxt = ST_READY;
          else if (!ctrl_busy) nxt = ST_SLEEP_MIN;
        end
        ST_SLEEP_MIN: if (tmr_zero) nxt = ST_SLEEP;
        ST_SLEEP:     if (!sleep_req) nxt = ST_WAKE;
        ST_WAKE:      if (tmr_zero) nxt = ST_READY;
        default:      nxt = ST_OFF;
      endcase
    end
  end

  // Load the shared timer on entry to a timed state.
  always_comb begin
    tmr_load = st_timed(nxt) && (nxt != state);
    unique case (nxt)
      ST_PWAIT:     tmr_val = PWRUP_LD;
      ST_WAKE:      tmr_val = WAKE_LD;
      ST_SLEEP_MIN: tmr_val = MIN_LD;
      default:      tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= nxt;
  end

  assert_drop_to_off_R1: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (state == ST_OFF));

  assert_sleep_only_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!st_asleep(state) && st_asleep(nxt)) |-> !ctrl_busy);

endmodule

// File: rtl/mpg_outreg.sv
module mpg_outreg
  import mem_pwr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  gate_st_e nxt,
  output logic     access_q,
  output logic     sleep_n_q,
  output logic     we_q
);

  // Outputs registered from the next state so they change on the same edge as the state.
  always_ff @(posedge clk) begin
    if (rst) begin
      access_q  <= 1'b0;
      sleep_n_q <= 1'b1;
      we_q      <= 1'b1;
    end else begin
      access_q  <= (nxt == ST_READY);
      sleep_n_q <= !st_asleep(nxt);
      we_q      <= (nxt == ST_OFF) || (nxt == ST_PWAIT);
    end
  end

endmodule

// File: rtl/mem_pwr_gate.sv
module mem_pwr_gate
  import mem_pwr_pkg::*;
#(
  parameter int unsigned PWRUP_CYC     = 45000,
  parameter int unsigned WAKE_CYC      = 45000,
  parameter int unsigned SLEEP_MIN_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic sleep_req,
  input  logic ctrl_busy,
  output logic sleep_n,
  output logic we_hold,
  output logic access_ok
);

  localparam int unsigned LONG_A  = (PWRUP_CYC > WAKE_CYC) ? PWRUP_CYC : WAKE_CYC;
  localparam int unsigned LONGEST = (LONG_A > SLEEP_MIN_CYC) ? LONG_A : SLEEP_MIN_CYC;
  localparam int          CNT_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);

  gate_st_e         state;
  gate_st_e         nxt;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             access_q;
  logic             sleep_n_q;
  logic             we_q;

  mpg_fsm #(
    .PWRUP_CYC    (PWRUP_CYC),
    .WAKE_CYC     (WAKE_CYC),
    .SLEEP_MIN_CYC(SLEEP_MIN_CYC),
    .CNT_W        (CNT_W)
  ) fsm_i (
    .clk      (clk),
    .rst      (rst),
    .supply_ok(supply_ok),
    .sleep_req(sleep_req),
    .ctrl_busy(ctrl_busy),
    .tmr_zero (tmr_zero),
    .state    (state),
    .nxt      (nxt),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  mpg_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  mpg_outreg out_i (
    .clk      (clk),
    .rst      (rst),
    .nxt      (nxt),
    .access_q (access_q),
    .sleep_n_q(sleep_n_q),
    .we_q     (we_q)
  );

  // Supply loss acts without waiting for an edge.
  assign access_ok = access_q & supply_ok;
  assign we_hold   = we_q | ~supply_ok;
  assign sleep_n   = sleep_n_q;

  assert_permit_after_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(access_q) |-> ($past(tmr_zero) || $past(state == ST_DRAIN)));

  assert_we_after_drop_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(supply_ok) |-> we_hold);

  assert_no_access_asleep_R3: assert property (@(posedge clk) disable iff (rst)
    !sleep_n |-> !access_ok);

  assert_min_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_n) |-> ($past(state == ST_SLEEP) || !$past(supply_ok)));

  assert_fall_idle_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_n) |-> !$past(ctrl_busy));

endmodule

// File: tb/mem_pwr_gate_tb_top.sv
module mem_pwr_gate_tb_top;

  localparam int P = 5;  // power-up holdoff
  localparam int W = 4;  // wake holdoff
  localparam int M = 3;  // minimum sleep time

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic sleep_req = 1'b0;
  logic ctrl_busy = 1'b0;
  logic sleep_n, we_hold, access_ok;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  mem_pwr_gate #(.PWRUP_CYC(P), .WAKE_CYC(W), .SLEEP_MIN_CYC(M)) dut_i (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .sleep_req(sleep_req),
    .ctrl_busy(ctrl_busy), .sleep_n(sleep_n), .we_hold(we_hold), .access_ok(access_ok)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic power_up();
    supply_ok = 1'b1;
    for (int i = 1; i <= P + 1; i++) begin
      step();
      chk("R2 access_ok", int'(access_ok), (i == P + 1) ? 1 : 0);
      chk("R2 we_hold", int'(we_hold), (i == P + 1) ? 0 : 1);
    end
  endtask

  task automatic wait_access(input string tag);
    for (int i = 0; i < 40; i++) begin
      if (access_ok) break;
      step();
    end
    chk(tag, int'(access_ok), 1);
  endtask

  initial begin
    @(negedge clk);
    repeat (3) step();
    chk("R10 access_ok", int'(access_ok), 0);
    chk("R10 sleep_n", int'(sleep_n), 1);
    chk("R10 we_hold", int'(we_hold), 1);
    rst = 1'b0;
    step();
    chk("R10 access_ok after", int'(access_ok), 0);
    chk("R10 we_hold after", int'(we_hold), 1);

    power_up();

    // R1: supply loss while ready
    supply_ok = 1'b0;
    #1;
    chk("R1 access_ok same cycle", int'(access_ok), 0);
    chk("R1 we_hold same cycle", int'(we_hold), 1);
    step();
    chk("R1 access_ok off", int'(access_ok), 0);
    chk("R1 sleep_n off", int'(sleep_n), 1);
    power_up();

    // R3/R6/R7/R8: sweep of request lengths; busy toggles during sleep
    for (int h = 1; h <= 6; h++) begin
      int e;
      e = (M + 2 > h + 1) ? M + 2 : h + 1;
      sleep_req = 1'b1;
      for (int i = 1; i <= e + W + 1; i++) begin
        step();
        if (i < e) chk("R3 R6 R8 sleep_n low", int'(sleep_n), 0);
        else       chk("R7 sleep_n high", int'(sleep_n), 1);
        chk("R3 R7 access_ok", int'(access_ok), (i >= e + W) ? 1 : 0);
        if (i == h) sleep_req = 1'b0;
        ctrl_busy = (i < e - 1) ? i[0] : 1'b0;
      end
    end

    // R4: drain lengths
    for (int d = 1; d <= 3; d++) begin
      sleep_req = 1'b1;
      ctrl_busy = 1'b1;
      for (int i = 1; i <= d + 1; i++) begin
        step();
        chk("R4 access_ok drain", int'(access_ok), 0);
        chk("R4 sleep_n drain", int'(sleep_n), (i <= d) ? 1 : 0);
        if (i == d) ctrl_busy = 1'b0;
      end
      sleep_req = 1'b0;
      wait_access("R7 wake after drain");
    end

    // R5: request withdrawn during drain
    sleep_req = 1'b1;
    ctrl_busy = 1'b1;
    step();
    chk("R5 access_ok drain", int'(access_ok), 0);
    chk("R5 sleep_n drain", int'(sleep_n), 1);
    sleep_req = 1'b0;
    step();
    chk("R5 access_ok back", int'(access_ok), 1);
    chk("R5 sleep_n kept", int'(sleep_n), 1);
    ctrl_busy = 1'b0;
    step();
    chk("R5 access_ok stays", int'(access_ok), 1);

    // R9: request held through power-up holdoff
    supply_ok = 1'b0;
    step();
    sleep_req = 1'b1;
    supply_ok = 1'b1;
    for (int i = 1; i <= P + 2; i++) begin
      step();
      chk("R9 sleep_n", int'(sleep_n), (i <= P + 1) ? 1 : 0);
      chk("R9 access_ok", int'(access_ok), (i == P + 1) ? 1 : 0);
    end

    // R1: supply loss while asleep
    supply_ok = 1'b0;
    #1;
    chk("R1 we_hold asleep", int'(we_hold), 1);
    step();
    chk("R1 sleep_n released", int'(sleep_n), 1);
    chk("R1 access_ok asleep", int'(access_ok), 0);
    sleep_req = 1'b0;
    step();
    power_up();

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule